// File: doc/BRIEF.md
# Two-wire register slave with auto-incrementing pointer

This block lets an external master on a two-wire serial bus read and write a small register bank. It watches the clock and data lines through synchronizers running on a faster system clock. From these it recognises bus conditions, assembles bytes, and checks the 7-bit device address carried in the first byte of every transfer. It acknowledges by pulling the data line low through an open-drain enable. The register bank sits outside the block, behind a parallel port that carries an address, a write strobe, write data and combinational read data.

A single 8-bit pointer serves both reads and writes. It keeps its value between transactions, so a read with no register address continues from the last register touched. The implemented map runs from 00H to 33H, which is not a power of two. The pointer wraps to 00H after the last register. A random read is a write header with a register-address byte, followed by a repeated START and a read header.

Top module: `i2c_reg_slave`

## Requirements
- R1: A START (data falling while clock is high), including a repeated START, restarts address reception. The slave pulls data low during the ninth clock of a header whose upper seven bits equal DEV_ADDR. On any other header it leaves data released and ignores the bus until the next START.
- R2: A header with bit 0 = 0 is a write. The first byte after it loads the pointer. Each later byte is written to the register at the pointer through a one-cycle `reg_wr_o` pulse. Every byte is acknowledged.
- R3: The pointer advances by one after every data byte, whether the byte was written or read.
- R4: When the pointer holds 33H or any higher value, advancing it gives 00H. A write burst past 33H therefore overwrites 00H onward.
- R5: The pointer is 00H after reset and is kept between transactions. A read header with no register address returns the register at n+1, where n is the last register read or written.
- R6: A random read returns first the register whose address was sent in the preceding write header.
- R7: When the master acknowledges a read byte (data low on the ninth clock), the next register follows. On a NACK, the slave releases data and sends nothing more until the next START.
- R8: A register-address byte above 33H is stored unchanged. Reads there return 00H, and data bytes there cause no `reg_wr_o` pulse.
- R9: Out of reset, data is released, `reg_wr_o` is low and `reg_addr_o` is 00H.
- R10: The data-line enable changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_addr_o | output | 8 | Register address, equal to the pointer |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data for the strobed register |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, combinational from the bank |

## Verification
The bench uses the default parameters: DEV_ADDR = 7'h3A, NUM_REGS = 52 and two synchronizer stages. With 52 registers, the last register 33H is reached by a three-byte burst. Reads and writes across the wrap can therefore be tested with short transfers. Every byte value from 34H up falls in the unimplemented window. The bank model returns EEH there, so the masking to 00H and the missing write strobe both show at the ports.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  // data edges while clock stays high are bus conditions
  assign start_o = scl_d & scl_i & sda_d & ~sda_i;
  assign stop_o  = scl_d & scl_i & ~sda_d & sda_i;
  assign rise_o  = ~scl_d & scl_i;
  assign fall_o  = scl_d & ~scl_i;
endmodule

// File: rtl/i2c_rs_ptr.sv
module i2c_rs_ptr #(
  parameter int          AW   = 8,
  parameter logic [AW-1:0] LAST = 8'h33
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (inc_i)  ptr_q <= (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  p_ptr_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_q < LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

  p_ptr_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_q >= LAST) |=> ptr_q == '0);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         NUM_REGS    = 52,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] reg_addr_o,
  output logic       reg_wr_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i
);
  localparam int         NLINES    = 2;
  localparam logic [7:0] LAST_ADDR = 8'(NUM_REGS - 1);

  logic [NLINES-1:0] line_raw, line_s;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  logic scl_s, sda_s;
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  logic start_det, stop_det, scl_rise, scl_fall;
  i2c_rs_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_s),
    .sda_i  (sda_s),
    .start_o(start_det),
    .stop_o (stop_det),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  rs_state_e  state_q;
  logic [2:0] bit_q;
  logic [7:0] shr_q, wdata_q, load_val_q;
  logic       rw_q, oe_q, ack_on_q, got_ack_q, wr_q, inc_q, load_q;
  logic [7:0] ptr, byte_in, rd_byte;

  i2c_rs_ptr #(.AW(8), .LAST(LAST_ADDR)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_q),
    .load_val_i(load_val_q),
    .inc_i     (inc_q),
    .ptr_o     (ptr)
  );

  assign byte_in = {shr_q[6:0], sda_s};
  assign rd_byte = (ptr > LAST_ADDR) ? 8'h00 : reg_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      shr_q      <= '0;
      wdata_q    <= '0;
      load_val_q <= '0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      ack_on_q   <= 1'b0;
      got_ack_q  <= 1'b0;
      wr_q       <= 1'b0;
      inc_q      <= 1'b0;
      load_q     <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      inc_q  <= 1'b0;
      load_q <= 1'b0;
      if (stop_det) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        ack_on_q  <= 1'b0;
        got_ack_q <= 1'b0;
      end else if (start_det) begin
        state_q   <= ST_ADDR;
        bit_q     <= '0;
        oe_q      <= 1'b0;
        ack_on_q  <= 1'b0;
        got_ack_q <= 1'b0;
      end else if (scl_rise) begin
        case (state_q)
          ST_ADDR, ST_REG, ST_WDATA: begin
            shr_q <= byte_in;
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              case (state_q)
                ST_ADDR: begin
                  if (byte_in[7:1] == DEV_ADDR) begin
                    state_q <= ST_ADDR_ACK;
                    rw_q    <= byte_in[0];
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                ST_REG: begin
                  state_q    <= ST_REG_ACK;
                  load_q     <= 1'b1;
                  load_val_q <= byte_in;
                end
                default: begin
                  state_q <= ST_WDATA_ACK;
                  wr_q    <= (ptr <= LAST_ADDR);
                  wdata_q <= byte_in;
                  inc_q   <= 1'b1;
                end
              endcase
            end
          end
          ST_RDATA: begin
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              state_q <= ST_RDATA_ACK;
              inc_q   <= 1'b1;
            end
          end
          ST_RDATA_ACK: begin
            if (!sda_s) got_ack_q <= 1'b1;
            else        state_q   <= ST_IDLE;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state_q)
          ST_ADDR_ACK, ST_REG_ACK, ST_WDATA_ACK: begin
            if (!ack_on_q) begin
              ack_on_q <= 1'b1;
              oe_q     <= 1'b1;
            end else begin
              ack_on_q <= 1'b0;
              bit_q    <= '0;
              if (state_q == ST_ADDR_ACK && rw_q) begin
                state_q <= ST_RDATA;
                shr_q   <= rd_byte;
                oe_q    <= ~rd_byte[7];
              end else begin
                oe_q    <= 1'b0;
                state_q <= (state_q == ST_ADDR_ACK) ? ST_REG : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            shr_q <= {shr_q[6:0], 1'b0};
            oe_q  <= ~shr_q[6];
          end
          ST_RDATA_ACK: begin
            if (got_ack_q) begin
              got_ack_q <= 1'b0;
              state_q   <= ST_RDATA;
              bit_q     <= '0;
              shr_q     <= rd_byte;
              oe_q      <= ~rd_byte[7];
            end else begin
              oe_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;

  p_start_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> state_q == ST_ADDR);

  p_wr_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> state_q == ST_WDATA_ACK);

  p_idle_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_o);

  p_wr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> reg_addr_o <= LAST_ADDR);

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int         Q   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       dut_oe;
  logic       sda_line;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr;
  logic [7:0] mem [0:63];
  int         wr_count = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] rb [0:3];

  assign sda_line  = m_sda & ~dut_oe;
  assign reg_rdata = (reg_addr < 8'd52) ? mem[reg_addr[5:0]] : 8'hEE;

  i2c_reg_slave u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (dut_oe),
    .reg_addr_o (reg_addr),
    .reg_wr_o   (reg_wr),
    .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr[5:0]] <= reg_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w();
    repeat (Q) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(); m_scl = 1'b1; w(); m_sda = 1'b0; w(); m_scl = 1'b0; w();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(); m_scl = 1'b1; w(); m_sda = 1'b1; w();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(); m_scl = 1'b1; w(); m_scl = 1'b0; w();
    end
    m_sda = 1'b1; w(); m_scl = 1'b1; w();
    ack = ~sda_line;
    m_scl = 1'b0; w();
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(); m_scl = 1'b1; w(); b[i] = sda_line; m_scl = 1'b0;
    end
    w(); m_sda = nack; w(); m_scl = 1'b1; w(); m_scl = 1'b0; w(); m_sda = 1'b1;
  endtask

  task automatic header(input logic rw, input string req);
    logic a;
    bus_start();
    send_byte({DEV, rw}, a);
    chk(req, {7'd0, a}, 8'd1);
  endtask

  task automatic write_regs(input logic [7:0] ra, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic a;
    logic [7:0] d [0:2];
    d[0] = d0; d[1] = d1; d[2] = d2;
    header(1'b0, "R1 header ack");
    send_byte(ra, a);
    chk("R2 reg byte ack", {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a);
      chk("R2 data ack", {7'd0, a}, 8'd1);
    end
    bus_stop();
  endtask

  task automatic read_bytes(input int n);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rb[k]);
    bus_stop();
  endtask

  task automatic cur_read(input int n);
    header(1'b1, "R1 read header ack");
    read_bytes(n);
  endtask

  task automatic rand_read(input logic [7:0] ra, input int n);
    logic a;
    header(1'b0, "R1 header ack");
    send_byte(ra, a);
    chk("R6 reg byte ack", {7'd0, a}, 8'd1);
    header(1'b1, "R1 repeated start ack");
    read_bytes(n);
  endtask

  task automatic t_reset();
    chk("R9 oe after reset", {7'd0, dut_oe}, 8'd0);
    chk("R9 wr after reset", {7'd0, reg_wr}, 8'd0);
    chk("R5 pointer after reset", reg_addr, 8'h00);
    cur_read(1);
    chk("R5 current read at reset", rb[0], 8'hC3);
    chk("R3 pointer after one read", reg_addr, 8'h01);
  endtask

  task automatic t_burst();
    write_regs(8'h05, 3, 8'hA1, 8'hA2, 8'hA3);
    chk("R3 pointer after write burst", reg_addr, 8'h08);
    rand_read(8'h05, 3);
    chk("R6 first byte", rb[0], 8'hA1);
    chk("R3 second byte", rb[1], 8'hA2);
    chk("R7 third byte", rb[2], 8'hA3);
  endtask

  task automatic t_current();
    write_regs(8'h10, 1, 8'h5A, 8'h00, 8'h00);
    cur_read(1);
    chk("R5 current read n+1", rb[0], 8'h11 ^ 8'hC3);
  endtask

  task automatic t_wrap();
    write_regs(8'h32, 3, 8'h11, 8'h22, 8'h33);
    rand_read(8'h00, 1);
    chk("R4 write wrapped to 00", rb[0], 8'h33);
    rand_read(8'h33, 2);
    chk("R4 read at 33", rb[0], 8'h22);
    chk("R4 read wraps to 00", rb[1], 8'h33);
  endtask

  task automatic t_mismatch();
    logic a;
    int wc;
    wc = wr_count;
    bus_start();
    send_byte({7'h2A, 1'b0}, a);
    chk("R1 foreign header no ack", {7'd0, a}, 8'd0);
    send_byte(8'h07, a);
    chk("R1 foreign byte no ack", {7'd0, a}, 8'd0);
    chk("R1 foreign oe released", {7'd0, dut_oe}, 8'd0);
    bus_stop();
    chk("R1 foreign no write", 8'(wr_count - wc), 8'd0);
    cur_read(1);
    chk("R1 pointer untouched", rb[0], 8'h01 ^ 8'hC3);
  endtask

  task automatic t_unimpl();
    logic a;
    int wc;
    header(1'b0, "R1 header ack");
    send_byte(8'h40, a);
    chk("R8 high reg byte ack", {7'd0, a}, 8'd1);
    bus_stop();
    chk("R8 high address stored", reg_addr, 8'h40);
    cur_read(2);
    chk("R8 unimplemented reads 00", rb[0], 8'h00);
    chk("R4 wrap from high address", rb[1], 8'h33);
    wc = wr_count;
    write_regs(8'h45, 1, 8'h99, 8'h00, 8'h00);
    chk("R8 no strobe above map", 8'(wr_count - wc), 8'd0);
  endtask

  task automatic t_nack();
    logic a;
    header(1'b0, "R1 header ack");
    send_byte(8'h08, a);
    header(1'b1, "R1 repeated start ack");
    recv_byte(1'b1, rb[0]);
    chk("R6 random read value", rb[0], 8'h08 ^ 8'hC3);
    w();
    chk("R7 released after nack", {7'd0, dut_oe}, 8'd0);
    bus_stop();
    cur_read(1);
    chk("R7 next read after nack", rb[0], 8'h09 ^ 8'hC3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i) ^ 8'hC3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_burst();
    t_current();
    t_wrap();
    t_mismatch();
    t_unimpl();
    t_nack();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule